// File: doc/BRIEF.md
# Partitioned SIMD Arithmetic Unit

This unit treats a 64-bit operand pair as a set of independent lanes and applies one arithmetic operation to every lane in parallel. The lane width is chosen per operation at run time: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Lane operations are wrapping add, wrapping subtract, equality compare and unsigned greater-than compare. Compares produce a mask, all ones or all zeros in each lane. Carries and borrows never leave the lane that produced them.

The unit also has a block-matching mode for motion estimation. Each accepted beat in this mode adds the sum of absolute differences of the eight byte pairs to a 16-bit accumulator. After 32 beats, which is one 16x16 pixel block of 16 rows with two words per row, the unit reports the block total and starts a new block. A clear input discards a partly accumulated block. Each operation is offered with a single valid strobe. Its result is registered, and a one-cycle done pulse marks it.

Top module: `simd_alu`

## Requirements
- R1: While rst_ni is low and after its release, before any valid beat, result_o is zero and done_o is low.
- R2: op_i = 0 (add), accepted with valid_i high: in the next cycle result_o holds, in every lane, (a + b) modulo 2^lane width, and done_o is high. lane_sel_i encodes the lane width as 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 32-bit. Lane k occupies bits [k*w +: w]. No carry enters a lane from a lower lane.
- R3: op_i = 1 (subtract) yields (a - b) modulo 2^lane width in each lane, one cycle after acceptance. No borrow crosses a lane boundary.
- R4: op_i = 2 (equality compare) writes all ones into each lane where a equals b and all zeros elsewhere.
- R5: op_i = 3 (greater compare) writes all ones into each lane where a is greater than b as unsigned numbers and all zeros elsewhere.
- R6: Each accepted lane operation (op_i 0 to 3) produces done_o high for exactly the following cycle. Back-to-back beats produce back-to-back results.
- R7: op_i = 4 (block distance) adds the sum of |a_byte - b_byte| over the eight bytes to a 16-bit accumulator, ignoring lane_sel_i. The first 31 beats of a block raise no done_o. One cycle after the 32nd beat, done_o is high and result_o holds the 16-bit total in bits [15:0], with zeros above.
- R8: After a block completes, the next block-distance beat starts a fresh block from a total of zero.
- R9: clear_i high zeroes the accumulator and the beat count. A block-distance beat accepted in the same cycle counts as the first beat of the new block.
- R10: Cycles without valid_i, and beats with op_i 5 to 7, raise no done_o, leave result_o unchanged and do not alter the block in progress.
- R11: Lane operations issued between block-distance beats return their own results and do not disturb the accumulated total or the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Beat strobe; inputs are taken when high |
| clear_i | input | 1 | Restart the block-distance accumulation |
| op_i | input | 3 | Operation: 0 add, 1 sub, 2 eq, 3 gt, 4 block distance |
| lane_sel_i | input | 2 | Lane width: 0 8-bit, 1 16-bit, 2 and 3 32-bit |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| result_o | output | 64 | Registered result |
| done_o | output | 1 | Result-valid pulse |

## Verification
The bench uses the default parameters: a 64-bit datapath, 32 beats per block and a 16-bit accumulator. With these values a full block of maximal byte differences reaches 65280, close to the top of the accumulator. Carry-cut patterns such as 0xFF + 0x01 in every byte reach every lane boundary at all three widths. The 32-beat count is short enough that several complete blocks can be run. These blocks include ones interrupted by lane operations, reserved codes, idle gaps and a clear that coincides with a beat.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam logic [1:0] LANE_B8  = 2'd0;
  localparam logic [1:0] LANE_H16 = 2'd1;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_CEQ = 3'd2;
  localparam logic [2:0] OP_CGT = 3'd3;
  localparam logic [2:0] OP_SAD = 3'd4;

  function automatic logic is_lane_op(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_CEQ) || (op == OP_CGT);
  endfunction
endpackage

// File: rtl/simd_lane_addsub.sv
module simd_lane_addsub #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic                sub_i,
  input  logic [DATA_W/8-1:0] lane_start_i,
  output logic [DATA_W-1:0]   sum_o
);
  localparam int NB = DATA_W / 8;

  logic [NB-1:0] cy;  // carry into each byte
  assign cy[0] = sub_i;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic       cin;
    logic [7:0] bx;
    // lane start cuts the chain: re-inject the subtract carry
    assign cin = lane_start_i[i] ? sub_i : cy[i];
    assign bx  = b_i[i*8 +: 8] ^ {8{sub_i}};
    if (i < NB - 1) begin : g_mid
      logic [8:0] s;
      assign s = {1'b0, a_i[i*8 +: 8]} + {1'b0, bx} + 9'(cin);
      assign sum_o[i*8 +: 8] = s[7:0];
      assign cy[i+1] = s[8];
    end else begin : g_top
      assign sum_o[i*8 +: 8] = a_i[i*8 +: 8] + bx + 8'(cin);
    end
  end
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        lane_sel_i,
  input  logic              gt_i,
  output logic [DATA_W-1:0] mask_o
);
  import simd_alu_pkg::*;
  localparam int KINDS = 3;

  logic [KINDS-1:0][DATA_W-1:0] kind_res;

  for (genvar g = 0; g < KINDS; g++) begin : g_kind
    localparam int W = 8 << g;
    localparam int N = DATA_W / W;
    for (genvar k = 0; k < N; k++) begin : g_lane
      logic hit;
      assign hit = gt_i ? (a_i[k*W +: W] > b_i[k*W +: W])
                        : (a_i[k*W +: W] == b_i[k*W +: W]);
      assign kind_res[g][k*W +: W] = {W{hit}};
    end
  end

  always_comb begin
    case (lane_sel_i)
      LANE_B8:  mask_o = kind_res[0];
      LANE_H16: mask_o = kind_res[1];
      default:  mask_o = kind_res[2];
    endcase
  end
endmodule

// File: rtl/simd_sad_sum.sv
module simd_sad_sum #(
  parameter int DATA_W = 64,
  parameter int SUM_W  = 11
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [SUM_W-1:0]  sum_o
);
  localparam int NB = DATA_W / 8;

  always_comb begin
    logic [7:0] pa, pb, d;
    sum_o = '0;
    for (int i = 0; i < NB; i++) begin
      pa = a_i[i*8 +: 8];
      pb = b_i[i*8 +: 8];
      d  = (pa > pb) ? (pa - pb) : (pb - pa);
      sum_o = sum_o + SUM_W'(d);
    end
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int SAD_WORDS = 32,
  parameter int ACC_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              clear_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        lane_sel_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o
);
  localparam int NB    = DATA_W / 8;
  localparam int SUM_W = $clog2(NB * 255 + 1);
  localparam int CNT_W = (SAD_WORDS > 1) ? $clog2(SAD_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(SAD_WORDS - 1);

  logic [NB-1:0]     lane_start;
  logic [DATA_W-1:0] addsub_res, cmp_res, lane_res;
  logic [SUM_W-1:0]  sad_sum;
  logic [ACC_W-1:0]  acc_q, acc_base, acc_next;
  logic [CNT_W-1:0]  cnt_q, cnt_base;
  logic              lane_fire, sad_fire, sad_last;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      case (lane_sel_i)
        LANE_B8:  lane_start[i] = 1'b1;
        LANE_H16: lane_start[i] = (i % 2 == 0);
        default:  lane_start[i] = (i % 4 == 0);
      endcase
    end
  end

  simd_lane_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i          (a_i),
    .b_i          (b_i),
    .sub_i        (op_i == OP_SUB),
    .lane_start_i (lane_start),
    .sum_o        (addsub_res)
  );

  simd_lane_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a_i        (a_i),
    .b_i        (b_i),
    .lane_sel_i (lane_sel_i),
    .gt_i       (op_i == OP_CGT),
    .mask_o     (cmp_res)
  );

  simd_sad_sum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_sad (
    .a_i   (a_i),
    .b_i   (b_i),
    .sum_o (sad_sum)
  );

  assign lane_res  = ((op_i == OP_ADD) || (op_i == OP_SUB)) ? addsub_res : cmp_res;
  assign lane_fire = valid_i && is_lane_op(op_i);
  assign sad_fire  = valid_i && (op_i == OP_SAD);

  // clear acts before a beat taken in the same cycle
  assign acc_base = clear_i ? '0 : acc_q;
  assign cnt_base = clear_i ? '0 : cnt_q;
  assign acc_next = acc_base + ACC_W'(sad_sum);
  assign sad_last = (cnt_base == LAST_BEAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      done_o   <= 1'b0;
      acc_q    <= '0;
      cnt_q    <= '0;
    end else begin
      done_o <= 1'b0;
      acc_q  <= acc_base;
      cnt_q  <= cnt_base;
      if (lane_fire) begin
        result_o <= lane_res;
        done_o   <= 1'b1;
      end else if (sad_fire) begin
        if (sad_last) begin
          result_o <= DATA_W'(acc_next);
          done_o   <= 1'b1;
          acc_q    <= '0;
          cnt_q    <= '0;
        end else begin
          acc_q <= acc_next;
          cnt_q <= cnt_base + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DATA_W = 64,
  parameter int ACC_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] result_o,
  input logic              done_o
);
  p_lane_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 3'd3) |=> done_o);

  p_idle_no_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || op_i > 3'd4) |=> !done_o);

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || op_i > 3'd4) |=> $stable(result_o));

  p_eq_all_ones_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2 && a_i == b_i) |=> (result_o == '1));

  p_gt_all_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3 && a_i == b_i) |=> (result_o == '0));

  p_sad_upper_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |=> (!done_o || result_o[DATA_W-1:ACC_W] == '0));
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o),
  .done_o   (done_o)
);

// File: tb/simd_alu_test.sv
`timescale 1ns/1ps
module simd_alu_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        clear_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  lane_sel_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [63:0] result_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference state
  logic [63:0] exp_res = '0;
  bit          exp_done = 0;
  int          ref_acc = 0;
  int          ref_cnt = 0;
  logic [63:0] seed = 64'h1234_5678_9abc_def0;

  always #10 clk_i = ~clk_i;

  simd_alu uut (
    .clk_i, .rst_ni, .valid_i, .clear_i, .op_i, .lane_sel_i,
    .a_i, .b_i, .result_o, .done_o
  );

  function automatic logic [63:0] ref_lane(input logic [2:0] op, input logic [1:0] ls,
                                           input logic [63:0] a, input logic [63:0] b);
    int w = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
    logic [63:0] mask = (64'd1 << w) - 64'd1;
    logic [63:0] r = '0;
    for (int k = 0; k < 64 / w; k++) begin
      logic [63:0] ua = (a >> (k * w)) & mask;
      logic [63:0] ub = (b >> (k * w)) & mask;
      logic [63:0] v;
      case (op)
        3'd0:    v = ua + ub;
        3'd1:    v = ua - ub;
        3'd2:    v = (ua == ub) ? mask : 64'd0;
        default: v = (ua > ub) ? mask : 64'd0;
      endcase
      r = r | ((v & mask) << (k * w));
    end
    return r;
  endfunction

  function automatic int ref_sad(input logic [63:0] a, input logic [63:0] b);
    int s = 0;
    for (int i = 0; i < 8; i++) begin
      int x = int'(a[i*8 +: 8]);
      int y = int'(b[i*8 +: 8]);
      s += (x > y) ? x - y : y - x;
    end
    return s;
  endfunction

  function automatic logic [63:0] rnd();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (result_o !== exp_res) begin
      fails++;
      $display("FAIL %s result actual=%h expected=%h", tag, result_o, exp_res);
    end
    checks++;
    if (done_o !== exp_done) begin
      fails++;
      $display("FAIL %s done actual=%b expected=%b", tag, done_o, exp_done);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit v, input bit clr, input logic [2:0] op, input logic [1:0] ls,
                      input logic [63:0] a, input logic [63:0] b, input string tag);
    valid_i = v; clear_i = clr; op_i = op; lane_sel_i = ls; a_i = a; b_i = b;
    @(posedge clk_i);
    exp_done = 0;
    if (clr) begin ref_acc = 0; ref_cnt = 0; end
    if (v && op <= 3'd3) begin
      exp_res  = ref_lane(op, ls, a, b);
      exp_done = 1;
    end else if (v && op == 3'd4) begin
      ref_acc = (ref_acc + ref_sad(a, b)) % 65536;
      ref_cnt++;
      if (ref_cnt == 32) begin
        exp_res  = 64'(ref_acc);
        exp_done = 1;
        ref_acc  = 0;
        ref_cnt  = 0;
      end
    end
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 3'd0, 2'd0, 64'h0, 64'h0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R6 actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    compare("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 after release");

    // R2 add: carry cut at every width
    for (int ls = 0; ls < 4; ls++) begin
      step(1, 0, 3'd0, 2'(ls), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, "R2 add carry cut");
      step(1, 0, 3'd0, 2'(ls), 64'h80FF_7F00_FFFF_0001, 64'h8001_0180_0001_FFFF, "R2 add mixed");
      step(1, 0, 3'd0, 2'(ls), rnd(), rnd(), "R2 add random");
    end
    // R3 sub: borrow cut
    for (int ls = 0; ls < 4; ls++) begin
      step(1, 0, 3'd1, 2'(ls), 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, "R3 sub borrow cut");
      step(1, 0, 3'd1, 2'(ls), rnd(), rnd(), "R3 sub random");
    end
    // R4 / R5 compares with partly equal lanes
    for (int ls = 0; ls < 4; ls++) begin
      step(1, 0, 3'd2, 2'(ls), 64'h1122_3344_5566_7788, 64'h1122_3345_5566_7788, "R4 eq partial");
      step(1, 0, 3'd2, 2'(ls), 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0001, "R4 eq all");
      step(1, 0, 3'd3, 2'(ls), 64'h8000_0001_7FFF_00FF, 64'h7FFF_0002_8000_00FE, "R5 gt unsigned");
      step(1, 0, 3'd3, 2'(ls), 64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, "R5 gt equal");
    end
    // R6 back-to-back then idle
    step(1, 0, 3'd0, 2'd1, 64'd1, 64'd2, "R6 b2b first");
    step(1, 0, 3'd1, 2'd2, 64'd9, 64'd4, "R6 b2b second");
    idle("R6 pulse ends");
    // R10 reserved codes
    step(1, 0, 3'd5, 2'd0, rnd(), rnd(), "R10 reserved 5");
    step(1, 0, 3'd6, 2'd1, rnd(), rnd(), "R10 reserved 6");
    step(1, 0, 3'd7, 2'd2, rnd(), rnd(), "R10 reserved 7");

    // R7 block with interleaved lane ops, gaps and reserved codes (R10, R11)
    for (int i = 0; i < 32; i++) begin
      step(1, 0, 3'd4, 2'(i % 4), rnd(), rnd(), "R7 block beat");
      if (i == 5)  step(1, 0, 3'd0, 2'd0, rnd(), rnd(), "R11 lane op inside block");
      if (i == 9)  idle("R10 gap inside block");
      if (i == 14) step(1, 0, 3'd6, 2'd0, rnd(), rnd(), "R10 reserved inside block");
      if (i == 20) step(1, 0, 3'd3, 2'd1, rnd(), rnd(), "R11 compare inside block");
    end
    idle("R7 after block");

    // R8 fresh block, maximal differences
    for (int i = 0; i < 32; i++)
      step(1, 0, 3'd4, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R8 max block");

    // R9 clear mid-block with coincident beat
    for (int i = 0; i < 10; i++)
      step(1, 0, 3'd4, 2'd0, rnd(), rnd(), "R9 partial block");
    step(1, 1, 3'd4, 2'd0, 64'h0000_0000_0000_00FF, 64'h0, "R9 clear with beat");
    for (int i = 0; i < 31; i++)
      step(1, 0, 3'd4, 2'd0, rnd(), rnd(), "R9 rest of block");
    // R9 clear alone
    for (int i = 0; i < 7; i++)
      step(1, 0, 3'd4, 2'd0, rnd(), rnd(), "R9 partial block 2");
    step(0, 1, 3'd0, 2'd0, 64'h0, 64'h0, "R9 clear alone");
    for (int i = 0; i < 32; i++)
      step(1, 0, 3'd4, 2'd0, rnd(), rnd(), "R9 block after clear");
    idle("R1 final idle");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule